// File: doc/BRIEF.md
# Battery-Low Check Sequencer

This block is the host-side master of a three-wire serial link (a frame strobe, a bit clock and one bidirectional data line) to an eight-channel converter. A single launch pulse makes it run a fixed script. It turns the converter's internal reference on and switches the battery-divider channel to analog. It then reads that channel repeatedly and decides whether the battery is low. Last, it puts the converter back into its low-power setup. The block reports the outcome through a one-cycle done pulse and a battery-low flag, which holds its value until the next launch.

A small frame engine produces the strobe, the bit clock and the outgoing data, and it captures the 8-bit conversion results. Each half of the bit clock lasts `HALF_DIV` system clocks. The host drives the data line only while the bit clock is low, and it samples returned data at the rising edge of the bit clock. The decision uses only the top bit of each result. A set top bit means the result is 128 or more, and this ends the check at once with the battery reported as good. A result below 128 adds one to a count, and the battery is reported low when that count reaches `LOW_LIMIT` (3).

Top module: `batt_chk_seq`

## Requirements
- R1: After reset and between frames, `link_start` is 1, `link_clk` is 0, `link_dio_oe` is 0, and `busy`, `done` and `batt_low` are 0.
- R2: The first frame of a run carries 7 bits, sent first to last: command 011, then pull-up 0, pull-down 1, reference-enable 1, test bit 0. The bits form 0110110 and take 7 bit-clock pulses.
- R3: The second frame carries 11 bits: command 001, then one attribute bit for each channel from 7 down to 0, where 1 means analog. For this frame the bits are 11100011, so the whole frame is 00111100011.
- R4: Each measurement frame drives 6 bits, command 100 and channel code 111. It lasts 16 bit-clock pulses, and the result is read MSB first at the rising edges of pulses 9 to 16.
- R5: A result whose bit 7 is 1 (value 128 or more) stops the measurements at once, and `batt_low` ends the run as 0.
- R6: Each result below 128 increments a count. When the count reaches 3, the measurements stop and `batt_low` ends the run as 1. Until then, another measurement frame follows.
- R7: Whatever the outcome, the run ends with a 7-bit frame 0110100 (reference off), followed by an 11-bit frame 00101100011 (channel 7 back to digital).
- R8: `link_start` stays 0 from the first bit of a frame to its end. `link_dio` and `link_dio_oe` change only while `link_clk` is 0.
- R9: `busy` is 1 from the cycle after the launch until the `done` pulse. `done` lasts exactly one cycle, and `busy` is 0 in the cycle after it. `batt_low` keeps its value until the next launch.
- R10: A `go` pulse while `busy` is 1 has no effect: the run keeps its frame count and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | One-cycle launch pulse |
| link_start | output | 1 | Frame strobe, low during a frame |
| link_clk | output | 1 | Bit clock to the converter |
| link_dio | output | 1 | Outgoing data bit |
| link_dio_oe | output | 1 | High while the host drives the data line |
| link_din | input | 1 | Data line value as seen by the host |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| batt_low | output | 1 | Outcome of the last run |

## Verification
The assertions take for granted that `link_din` changes only while the bit clock is low and stays steady across each rising edge, because the engine latches it in the cycle the clock rises. They also assume that `go` is a synchronous pulse, with no relation to the frame timing. The bench's converter model changes the line only at falling bit-clock edges, and only during pulses 9 to 16 of a measurement frame. It drives `go` on falling system-clock edges, including one pulse in the middle of a run.

// File: rtl/batt_chk_pkg.sv
// Shared widths, command codes, frame descriptor and state types for the
// battery-low check sequencer. Assumes at most 31 bit-clock pulses per frame.
package batt_chk_pkg;
    localparam int FRAME_W = 11;   // widest outgoing bit field (command + 8 attributes)
    localparam int IDX_W   = 5;    // bit-pulse index width
    localparam int RES_W   = 8;    // conversion result width

    localparam logic [2:0] CMD_CTRL = 3'b011;
    localparam logic [2:0] CMD_ATTR = 3'b001;
    localparam logic [2:0] CMD_CONV = 3'b100;

    typedef struct packed {
        logic [FRAME_W-1:0] word;   // outgoing bits, first bit at the MSB
        logic [IDX_W-1:0]   n_out;  // number of driven bits
        logic [IDX_W-1:0]   n_tot;  // number of bit-clock pulses
        logic               rd;     // capture the last RES_W bits
    } frame_t;

    typedef enum logic [1:0] {F_IDLE, F_LO, F_HI, F_TAIL} fstate_t;

    typedef enum logic [2:0] {
        C_IDLE, C_REF_ON, C_ANA, C_MEAS, C_REF_OFF, C_DIG, C_FIN
    } cstate_t;
endpackage

// File: rtl/link_tick.sv
// Half-period timer for the bit clock: pulses tick once every HALF_DIV
// cycles while en is high, restarting from zero whenever en drops.
// Assumes HALF_DIV >= 1.
module link_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/frame_engine.sv
// Bit-serial frame engine: lowers the strobe, sends n_out bits MSB first
// while the bit clock is low, runs n_tot bit-clock pulses, and when rd is
// set shifts in the data line on the rising edges of the last RES_W pulses.
// Assumes launch is only raised while idle is high.
module frame_engine
    import batt_chk_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   launch,
    input  frame_t desc,
    output logic   idle,
    output logic   fdone,
    output logic   res_msb,
    output logic   lk_start,
    output logic   lk_clk,
    output logic   lk_dio,
    output logic   lk_oe,
    input  logic   lk_din
);
    fstate_t           st;
    frame_t            cur;
    logic [IDX_W-1:0]  idx;
    logic [RES_W-1:0]  rx;
    logic              tick;
    logic [IDX_W-1:0]  rd_from;
    logic              bit_sel;

    link_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st != F_IDLE),
        .tick (tick)
    );

    assign rd_from = cur.n_tot - IDX_W'(RES_W);

    // Walk the frame: low half, high half per pulse, then a closing half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= F_IDLE;
            cur   <= '0;
            idx   <= '0;
            rx    <= '0;
            fdone <= 1'b0;
        end else begin
            fdone <= 1'b0;
            case (st)
                F_IDLE: if (launch) begin
                    cur <= desc;
                    idx <= '0;
                    st  <= F_LO;
                end
                F_LO: if (tick) begin
                    st <= F_HI;
                    if (cur.rd && idx >= rd_from)
                        rx <= {rx[RES_W-2:0], lk_din};
                end
                F_HI: if (tick) begin
                    if (idx == cur.n_tot - IDX_W'(1))
                        st <= F_TAIL;
                    else begin
                        idx <= idx + 1'b1;
                        st  <= F_LO;
                    end
                end
                F_TAIL: if (tick) begin
                    st    <= F_IDLE;
                    fdone <= 1'b1;
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // Pick the outgoing bit for the current pulse index.
    always_comb begin
        bit_sel = 1'b0;
        for (int i = 0; i < FRAME_W; i++)
            if (idx == IDX_W'(i))
                bit_sel = cur.word[FRAME_W-1-i];
    end

    assign idle     = (st == F_IDLE);
    assign lk_start = (st == F_IDLE);
    assign lk_clk   = (st == F_HI);
    assign lk_oe    = (st == F_LO || st == F_HI) && (idx < cur.n_out);
    assign lk_dio   = lk_oe && bit_sel;
    assign res_msb  = rx[RES_W-1];

    // R8: outgoing data holds steady across the high half of the bit clock.
    a_r8_dio_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_clk && $past(lk_clk)) |-> ($stable(lk_dio) && $stable(lk_oe)));

    // R8: the bit clock only pulses inside a frame.
    a_r8_clk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        lk_clk |-> !lk_start);

    // R1: outside a frame the data line is released and the clock rests low.
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        lk_start |-> (!lk_oe && !lk_clk));

    // R4: the result register moves only during capture frames.
    a_r4_capture_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !cur.rd |=> $stable(rx));
endmodule

// File: rtl/batt_script.sv
// Command script for the battery-low check: reference on, channel to
// analog, repeated measurements, then reference off and channel to
// digital. One frame is issued per step; the step advances on fdone.
// Assumes fdone arrives once per launched frame and res_msb is valid then.
module batt_script
    import batt_chk_pkg::*;
#(
    parameter int         LOW_LIMIT = 3,
    parameter int         CHAN      = 7,
    parameter logic [7:0] BASE_ATTR = 8'h63
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   go,
    input  logic   fe_idle,
    input  logic   fdone,
    input  logic   res_msb,
    output logic   launch,
    output frame_t desc,
    output logic   busy,
    output logic   done,
    output logic   batt_low
);
    localparam int         CNT_W     = $clog2(LOW_LIMIT + 1);
    localparam logic [7:0] MEAS_ATTR = BASE_ATTR | (8'd1 << CHAN);
    localparam logic [2:0] CHAN_CODE = 3'(CHAN);

    cstate_t          st;
    logic             pend;
    logic [CNT_W-1:0] cnt;
    logic             step;

    assign step   = (st == C_REF_ON) || (st == C_ANA) || (st == C_MEAS) ||
                    (st == C_REF_OFF) || (st == C_DIG);
    assign launch = step && !pend && fe_idle;
    assign busy   = (st != C_IDLE);
    assign done   = (st == C_FIN);

    // Track whether the current step's frame is already in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (launch)
            pend <= 1'b1;
        else if (fdone)
            pend <= 1'b0;
    end

    // Advance the script, count low results and settle the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= C_IDLE;
            cnt      <= '0;
            batt_low <= 1'b0;
        end else begin
            case (st)
                C_IDLE: if (go) begin
                    st       <= C_REF_ON;
                    cnt      <= '0;
                    batt_low <= 1'b0;
                end
                C_REF_ON:  if (fdone) st <= C_ANA;
                C_ANA:     if (fdone) st <= C_MEAS;
                C_MEAS: if (fdone) begin
                    if (res_msb)
                        st <= C_REF_OFF;
                    else if (cnt == CNT_W'(LOW_LIMIT - 1)) begin
                        cnt      <= cnt + 1'b1;
                        batt_low <= 1'b1;
                        st       <= C_REF_OFF;
                    end else
                        cnt <= cnt + 1'b1;
                end
                C_REF_OFF: if (fdone) st <= C_DIG;
                C_DIG:     if (fdone) st <= C_FIN;
                C_FIN:     st <= C_IDLE;
                default:   st <= C_IDLE;
            endcase
        end
    end

    // Describe the frame belonging to the current step.
    always_comb begin
        desc = '0;
        case (st)
            C_REF_ON:  desc = '{word: {CMD_CTRL, 4'b0110, 4'b0000},
                               n_out: IDX_W'(7), n_tot: IDX_W'(7), rd: 1'b0};
            C_ANA:     desc = '{word: {CMD_ATTR, MEAS_ATTR},
                               n_out: IDX_W'(11), n_tot: IDX_W'(11), rd: 1'b0};
            C_MEAS:    desc = '{word: {CMD_CONV, CHAN_CODE, 5'b00000},
                               n_out: IDX_W'(6), n_tot: IDX_W'(16), rd: 1'b1};
            C_REF_OFF: desc = '{word: {CMD_CTRL, 4'b0100, 4'b0000},
                               n_out: IDX_W'(7), n_tot: IDX_W'(7), rd: 1'b0};
            C_DIG:     desc = '{word: {CMD_ATTR, BASE_ATTR},
                               n_out: IDX_W'(11), n_tot: IDX_W'(11), rd: 1'b0};
            default:   desc = '0;
        endcase
    end

    // R9: the done pulse is followed by an idle cycle.
    a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10: busy ends only through done, whatever go does.
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6: the low flag rises only once the limit of low results is reached.
    a_r6_low_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batt_low) |-> (cnt == CNT_W'(LOW_LIMIT)));

    // R5: a result with its top bit set never raises the low flag.
    a_r5_high_result_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_MEAS && fdone && res_msb) |=> !batt_low);

    // R9: while idle the outcome is held.
    a_r9_outcome_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(batt_low));
endmodule

// File: rtl/batt_chk_seq.sv
// Top of the battery-low check sequencer: joins the command script to the
// bit-serial frame engine. Assumes go is synchronous to clk.
module batt_chk_seq
    import batt_chk_pkg::*;
#(
    parameter int         HALF_DIV  = 4,
    parameter int         LOW_LIMIT = 3,
    parameter int         CHAN      = 7,
    parameter logic [7:0] BASE_ATTR = 8'h63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic link_start,
    output logic link_clk,
    output logic link_dio,
    output logic link_dio_oe,
    input  logic link_din,
    output logic busy,
    output logic done,
    output logic batt_low
);
    frame_t desc;
    logic   launch;
    logic   fe_idle;
    logic   fdone;
    logic   res_msb;

    batt_script #(
        .LOW_LIMIT(LOW_LIMIT),
        .CHAN     (CHAN),
        .BASE_ATTR(BASE_ATTR)
    ) u_script (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .fe_idle (fe_idle),
        .fdone   (fdone),
        .res_msb (res_msb),
        .launch  (launch),
        .desc    (desc),
        .busy    (busy),
        .done    (done),
        .batt_low(batt_low)
    );

    frame_engine #(
        .HALF_DIV(HALF_DIV)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .desc    (desc),
        .idle    (fe_idle),
        .fdone   (fdone),
        .res_msb (res_msb),
        .lk_start(link_start),
        .lk_clk  (link_clk),
        .lk_dio  (link_dio),
        .lk_oe   (link_dio_oe),
        .lk_din  (link_din)
    );
endmodule

// File: tb/batt_chk_seq_test.sv
// Scoreboard bench: the driver task queues the expected frames of a run,
// a link monitor rebuilds each frame and compares it on the strobe's rise,
// and a converter model answers measurement frames from a result queue.
module batt_chk_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic link_din = 1'b0;
    logic link_start, link_clk, link_dio, link_dio_oe;
    logic busy, done, batt_low;

    int checks = 0;
    int errors = 0;

    logic [20:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  resp_q[$];
    logic [7:0]  cur_resp = 8'h00;

    int          m_clk = 0;
    int          m_out = 0;
    logic [10:0] m_bits = '0;

    batt_chk_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .link_start (link_start),
        .link_clk   (link_clk),
        .link_dio   (link_dio),
        .link_dio_oe(link_dio_oe),
        .link_din   (link_din),
        .busy       (busy),
        .done       (done),
        .batt_low   (batt_low)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [20:0] mk(input int nclk, input int nout, input logic [10:0] bits);
        return {5'(nclk), 5'(nout), bits};
    endfunction

    // Monitor: frame start resets the record.
    always @(negedge link_start) begin
        m_clk  = 0;
        m_out  = 0;
        m_bits = '0;
    end

    // Monitor: collect driven bits at each rising bit-clock edge.
    always @(posedge link_clk) begin
        m_clk++;
        if (link_dio_oe) begin
            m_bits = {m_bits[9:0], link_dio};
            m_out++;
        end
    end

    // Converter model: present result bits after falling edges 8..15.
    always @(negedge link_clk) begin
        if (m_clk >= 8 && m_clk <= 15 && m_out == 6) begin
            if (m_clk == 8)
                cur_resp = (resp_q.size() > 0) ? resp_q.pop_front() : 8'h00;
            link_din = cur_resp[15 - m_clk];
        end
    end

    // Monitor: compare each finished frame against the scoreboard.
    always @(posedge link_start) begin
        if (rst_n) begin
            if (exp_q.size() == 0)
                check(1'b0, "R10", "unexpected frame (bits)", int'(m_bits), 0);
            else begin
                logic [20:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({5'(m_clk), 5'(m_out), m_bits} == e, t, "frame clocks/bits",
                      int'({5'(m_clk), 5'(m_out), m_bits}), int'(e));
            end
        end
    end

    // Driver: queue expectations for one run and launch it.
    task automatic run_case(input logic [7:0] r0, input logic [7:0] r1,
                            input logic [7:0] r2, input bit extra_go, input string otag);
        logic [7:0] rr[3];
        int  n;
        bit  low;
        int  t;
        rr = '{r0, r1, r2};
        n = 0;
        low = 1'b0;
        for (int i = 0; i < 3; i++) begin
            n++;
            if (rr[i][7]) break;
            if (i == 2) low = 1'b1;
        end
        for (int i = 0; i < n; i++) resp_q.push_back(rr[i]);
        exp_q.push_back(mk(7, 7, 11'b00000110110));  tag_q.push_back("R2");
        exp_q.push_back(mk(11, 11, 11'b00111100011)); tag_q.push_back("R3");
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(mk(16, 6, 11'b00000100111)); tag_q.push_back("R4");
        end
        exp_q.push_back(mk(7, 7, 11'b00000110100));  tag_q.push_back("R7");
        exp_q.push_back(mk(11, 11, 11'b00101100011)); tag_q.push_back("R7");

        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        check(busy == 1'b1, "R9", "busy after launch", busy, 1);
        if (extra_go) begin
            repeat (60) @(negedge clk);
            go = 1'b1;
            @(negedge clk) go = 1'b0;
        end
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(done == 1'b1, "R9", "done pulse seen", done, 1);
        check(batt_low == low, otag, "battery-low outcome", batt_low, low);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R9", "single done pulse, busy off",
              {done, busy}, 0);
        repeat (300) @(negedge clk);
        check(batt_low == low, "R9", "outcome held while idle", batt_low, low);
        check(exp_q.size() == 0, "R10", "frames left unmatched", exp_q.size(), 0);
        check(link_start && !link_clk && !link_dio_oe, "R1", "link idle after run",
              {link_start, link_clk, link_dio_oe}, 4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(link_start == 1'b1, "R1", "reset link_start", link_start, 1);
        check(link_clk == 1'b0 && link_dio_oe == 1'b0, "R1", "reset clk/oe",
              {link_clk, link_dio_oe}, 0);
        check(busy == 1'b0 && done == 1'b0 && batt_low == 1'b0, "R1",
              "reset status", {busy, done, batt_low}, 0);

        run_case(8'd200, 8'd0, 8'd0, 1'b0, "R5");        // first result high
        run_case(8'h7F, 8'h7F, 8'h7F, 1'b0, "R6");       // three just-below results
        run_case(8'h10, 8'h80, 8'h00, 1'b0, "R5");       // low then exactly 128
        run_case(8'h80, 8'h00, 8'h00, 1'b0, "R5");       // boundary 128 first
        run_case(8'h00, 8'h7F, 8'h01, 1'b1, "R6");       // low run with go while busy (R10)
        run_case(8'h7F, 8'h00, 8'hFF, 1'b1, "R5");       // two low, then high; go ignored

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule